// File: doc/BRIEF.md
# Full-Duplex Serial Port Engine

This block is the serial port of a small controller. Software reaches it over a byte-wide register bus with two locations. The control location holds the mode selection, the receive enable, the address-filter bit, a spare transmit bit, the received stop bit and the two completion flags. The data location is two physical buffers behind one address. A write fills the transmit side and starts a frame. A read returns the last byte the receiver accepted.

There are two operating modes. In the synchronous mode the port is a shift register. Eight bits move LSB first on the bidirectional data line. The clock line carries a shift clock with a period of twelve system clocks. In the asynchronous mode the port sends and receives ten-bit frames. The bit rate comes from an external timer overflow pulse, scaled by a rate-doubling input. The receiver oversamples each bit sixteen times, rejects false start edges, and filters incoming bytes. A byte is discarded while the previous one is still unread, and also when filtering is on and the stop bit is zero.

Top module: `sport_engine`

## Requirements
- R1: After reset the control location reads 0x00 and the data location reads 0x00. The clock line `txd` is 1, `rxd_oe` is 0, and `ti`, `ri` and `irq` are 0.
- R2: The control byte is laid out MSB to LSB as: mode-high, mode-select, filter, receive-enable, spare transmit bit, received stop bit, transmit-done, receive-done. A write to it (`reg_sel`=0) is read back unchanged. Bit 6 = 1 selects the asynchronous mode and bit 6 = 0 selects the shift-register mode. `ti` and `ri` show bits 1 and 0, and `irq` is their OR.
- R3: A write to the data location (`reg_sel`=1) does not change what that location reads. A read always returns the receive buffer.
- R4: In the asynchronous mode, a data write sends a 0 start bit, the eight data bits LSB first, and a 1 stop bit on `txd`. The transmit-done flag is set once the stop bit ends.
- R5: In the asynchronous mode one bit lasts 16 overflow pulses when `baud_dbl`=1 and 32 overflow pulses when `baud_dbl`=0, for both sending and receiving.
- R6: In the shift-register mode, a data write drives the byte LSB first on `rxd_out` with `rxd_oe`=1, twelve clocks per bit. Within each bit, `txd` is low for the first six clocks and high for the last six. The transmit-done flag is set 96 clocks after the write edge.
- R7: In the shift-register mode, reception starts only while receive-enable is 1 and receive-done is 0. `rxd_in` is sampled in the high half of each shift clock, and the byte is placed in the receive buffer with receive-done set. No new reception starts while receive-done stays 1.
- R8: In the asynchronous mode with receive-enable set, a valid frame on `rxd_in` loads the byte into the receive buffer, copies the stop bit into control bit 2, and sets receive-done.
- R9: With receive-enable at 0 nothing is received in either mode. In the shift-register mode no shift clock appears.
- R10: A frame that completes while receive-done is 1 is dropped, and the receive buffer keeps its old byte.
- R11: With the filter bit at 1, a frame whose stop bit is 0 is dropped. A frame whose stop bit is 1 is accepted. With the filter bit at 0, a stop bit of 0 is still accepted, and control bit 2 reads 0.
- R12: A low pulse on `rxd_in` shorter than half a bit is not taken as a start bit. No byte is loaded, and the next valid frame is received normally.
- R13: Transmit-done and receive-done stay set until software writes the control location. Hardware never clears them.
- R14: A data write while a frame is being sent is ignored. The frame in progress finishes unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control location, 1 = data location |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the location picked by `reg_sel` |
| baud_ovf | input | 1 | One-cycle timer overflow pulse |
| baud_dbl | input | 1 | Rate doubler: 1 gives 16 overflows per bit, 0 gives 32 |
| rxd_in | input | 1 | Receive line input |
| rxd_out | output | 1 | Data line output in shift-register mode |
| rxd_oe | output | 1 | Output enable for `rxd_out` |
| txd | output | 1 | Asynchronous transmit line, or the shift clock in shift-register mode |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| irq | output | 1 | OR of the two flags |

## Verification
The bench targets the acceptance rule at its edges.

- It sends frames while the previous byte is still unread. A receiver that ignored that rule would overwrite the buffer.
- It sends stop bits of 0 with the filter on and with it off. A wrong filter either loses good bytes or keeps bad ones, and a wrong flag copy leaves the stop-bit flag stale.
- It injects a short low glitch. A receiver without the mid-start check would report a phantom byte.
- It writes the data location during a frame. A transmitter that restarted on that write would corrupt the frame or send a second one.
- In the shift-register mode it checks every clock of the shift clock and data against the expected twelve-clock pattern. It also checks that the flags survive idle cycles, which catches any hardware clearing.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic sm_hi;
        logic sm_sel;
        logic filt;
        logic ren;
        logic tbit;
        logic rstop;
        logic txf;
        logic rxf;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } urx_st_e;

endpackage

// File: rtl/sport_baud.sv
module sport_baud #(
    parameter int OVF_PRE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic dbl,
    output logic subtick
);
    localparam int CW = (OVF_PRE > 1) ? $clog2(OVF_PRE) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OVF_PRE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bd_t;

    bd_t bd_q, bd_d;

    always_comb begin
        bd_d    = bd_q;
        subtick = 1'b0;
        if (ovf) begin
            subtick = dbl || (bd_q.cnt == CNT_LAST);
            if (bd_q.cnt == CNT_LAST) bd_d.cnt = '0;
            else                      bd_d.cnt = bd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bd_q <= '0;
        else        bd_q <= bd_d;
    end

    if (OVF_PRE > 1) begin : g_chk
        // R5: without doubling, two prescaled ticks never come back to back
        p_prescale_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (subtick && !dbl) |=> !(subtick && !dbl))
            else $error("prescaled ticks adjacent");
    end

endmodule

// File: rtl/sport_utx.sv
module sport_utx #(
    parameter int DW  = 8,
    parameter int SPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          subtick,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int NB = DW + 2;
    localparam int IW = $clog2(NB);
    localparam int SW = $clog2(SPB);
    localparam logic [IW-1:0] IDX_LAST = IW'(NB - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SPB - 1);

    typedef struct packed {
        logic          busy;
        logic [NB-1:0] frame;
        logic [IW-1:0] idx;
        logic [SW-1:0] sub;
    } utx_t;

    utx_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        done = 1'b0;
        if (!tx_q.busy) begin
            if (start) begin
                tx_d.busy  = 1'b1;
                tx_d.frame = {1'b1, din, 1'b0};
                tx_d.idx   = '0;
                tx_d.sub   = '0;
            end
        end else if (subtick) begin
            if (tx_q.sub == SUB_LAST) begin
                tx_d.sub   = '0;
                tx_d.frame = {1'b1, tx_q.frame[NB-1:1]};
                if (tx_q.idx == IDX_LAST) begin
                    tx_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    tx_d.idx = tx_q.idx + 1'b1;
                end
            end else begin
                tx_d.sub = tx_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign txd  = tx_q.busy ? tx_q.frame[0] : 1'b1;
    assign busy = tx_q.busy;

    // R4: an accepted start drives the start bit low on the next cycle
    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !txd)
        else $error("start bit not low");

    // R4: the end of the stop bit releases the transmitter
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && txd))
        else $error("transmitter still busy after frame");

endmodule

// File: rtl/sport_shift0.sv
module sport_shift0 #(
    parameter int DW  = 8,
    parameter int DIV = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [DW-1:0] din,
    input  logic          rxd_s,
    output logic          sclk,
    output logic          dout,
    output logic          oe,
    output logic          busy,
    output logic          tx_done,
    output logic          rx_done,
    output logic [DW-1:0] rx_data
);
    localparam int PW = $clog2(DIV);
    localparam int BW = $clog2(DW);
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] PH_MID  = PW'(DIV / 2);
    localparam logic [BW-1:0] B_LAST  = BW'(DW - 1);

    typedef struct packed {
        logic          busy;
        logic          is_tx;
        logic [PW-1:0] phase;
        logic [BW-1:0] bidx;
        logic [DW-1:0] sh;
    } sh_t;

    sh_t sh_q, sh_d;
    logic last_slot;

    assign last_slot = sh_q.busy && (sh_q.phase == PH_LAST) && (sh_q.bidx == B_LAST);

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.busy) begin
            if (start_tx || start_rx) begin
                sh_d.busy  = 1'b1;
                sh_d.is_tx = start_tx;
                sh_d.phase = '0;
                sh_d.bidx  = '0;
                sh_d.sh    = start_tx ? din : '0;
            end
        end else begin
            if (!sh_q.is_tx && sh_q.phase == PH_MID)
                sh_d.sh = {rxd_s, sh_q.sh[DW-1:1]};
            if (sh_q.phase == PH_LAST) begin
                sh_d.phase = '0;
                if (sh_q.is_tx) sh_d.sh = {1'b0, sh_q.sh[DW-1:1]};
                if (sh_q.bidx == B_LAST) sh_d.busy = 1'b0;
                else                     sh_d.bidx = sh_q.bidx + 1'b1;
            end else begin
                sh_d.phase = sh_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sclk    = sh_q.busy ? (sh_q.phase >= PH_MID) : 1'b1;
    assign dout    = sh_q.sh[0];
    assign oe      = sh_q.busy && sh_q.is_tx;
    assign busy    = sh_q.busy;
    assign tx_done = last_slot && sh_q.is_tx;
    assign rx_done = last_slot && !sh_q.is_tx;
    assign rx_data = sh_q.sh;

    // R6: a transmit start enables the data driver with the clock low
    p_tx_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx && !busy) |=> (oe && !sclk))
        else $error("shift transmit did not begin");

    // R7: the shifter goes idle right after a completed receive
    p_rx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (!busy && !oe))
        else $error("shift receive did not end");

endmodule

// File: rtl/sport_urx.sv
module sport_urx #(
    parameter int DW  = 8,
    parameter int SPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          subtick,
    input  logic          rxd_s,
    output logic          done,
    output logic          stop_bit,
    output logic [DW-1:0] data
);
    import sport_pkg::*;

    localparam int SW = $clog2(SPB);
    localparam int BW = $clog2(DW);
    localparam logic [SW-1:0] SUB_LAST  = SW'(SPB - 1);
    localparam logic [SW-1:0] HALF_LAST = SW'(SPB / 2 - 1);
    localparam logic [BW-1:0] B_LAST    = BW'(DW - 1);

    typedef struct packed {
        urx_st_e       st;
        logic          prev;
        logic [SW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic [DW-1:0] sh;
    } urx_t;

    urx_t rx_q, rx_d;

    always_comb begin
        rx_d = rx_q;
        done = 1'b0;
        if (!enable) begin
            rx_d.st   = RX_IDLE;
            rx_d.prev = 1'b1;
        end else if (subtick) begin
            unique case (rx_q.st)
                RX_IDLE: begin
                    if (rx_q.prev && !rxd_s) begin
                        rx_d.st  = RX_START;
                        rx_d.cnt = '0;
                    end
                    rx_d.prev = rxd_s;
                end
                RX_START: begin
                    if (rx_q.cnt == HALF_LAST) begin
                        rx_d.cnt  = '0;
                        rx_d.bidx = '0;
                        if (rxd_s) begin
                            rx_d.st   = RX_IDLE;
                            rx_d.prev = 1'b1;
                        end else begin
                            rx_d.st = RX_DATA;
                        end
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (rx_q.cnt == SUB_LAST) begin
                        rx_d.cnt = '0;
                        rx_d.sh  = {rxd_s, rx_q.sh[DW-1:1]};
                        if (rx_q.bidx == B_LAST) rx_d.st   = RX_STOP;
                        else                     rx_d.bidx = rx_q.bidx + 1'b1;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (rx_q.cnt == SUB_LAST) begin
                        done      = 1'b1;
                        rx_d.st   = RX_IDLE;
                        rx_d.prev = rxd_s;
                        rx_d.cnt  = '0;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
                default: rx_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.st   <= RX_IDLE;
            rx_q.prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign stop_bit = rxd_s;
    assign data     = rx_q.sh;

    // R9: a disabled receiver sits idle
    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rx_q.st == RX_IDLE))
        else $error("receiver active while disabled");

    // R12: a line found high at mid start abandons the frame
    p_false_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && subtick && rx_q.st == RX_START && rx_q.cnt == HALF_LAST && rxd_s)
        |=> (rx_q.st == RX_IDLE))
        else $error("false start not rejected");

endmodule

// File: rtl/sport_engine.sv
module sport_engine #(
    parameter int SUB_PER_BIT = 16,
    parameter int M0_DIV      = 12,
    parameter int OVF_PRE     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       baud_ovf,
    input  logic       baud_dbl,
    input  logic       rxd_in,
    output logic       rxd_out,
    output logic       rxd_oe,
    output logic       txd,
    output logic       ti,
    output logic       ri,
    output logic       irq
);
    import sport_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [BYTE_W-1:0] rbuf;
        logic [1:0]        sync;
    } top_t;

    top_t t_q, t_d;

    logic              rxd_s, mode_async, wr_ctrl, wr_data;
    logic              subtick;
    logic              utx_start, utx_txd, utx_busy, utx_done;
    logic              sh_start_tx, sh_start_rx, sh_sclk, sh_dout, sh_oe, sh_busy;
    logic              sh_tx_done, sh_rx_done;
    logic [BYTE_W-1:0] sh_rx_data;
    logic              urx_done, urx_stop;
    logic [BYTE_W-1:0] urx_data;

    assign rxd_s       = t_q.sync[1];
    assign mode_async  = t_q.ctrl.sm_sel;
    assign wr_ctrl     = reg_wr && !reg_sel;
    assign wr_data     = reg_wr && reg_sel;
    assign utx_start   = wr_data && mode_async && !utx_busy && !sh_busy;
    assign sh_start_tx = wr_data && !mode_async && !utx_busy && !sh_busy;
    assign sh_start_rx = !mode_async && t_q.ctrl.ren && !t_q.ctrl.rxf
                         && !utx_busy && !sh_busy && !wr_data;

    sport_baud #(.OVF_PRE(OVF_PRE)) u_baud (
        .clk(clk), .rst_n(rst_n), .ovf(baud_ovf), .dbl(baud_dbl), .subtick(subtick)
    );

    sport_utx #(.DW(BYTE_W), .SPB(SUB_PER_BIT)) u_utx (
        .clk(clk), .rst_n(rst_n), .start(utx_start), .din(reg_wdata),
        .subtick(subtick), .txd(utx_txd), .busy(utx_busy), .done(utx_done)
    );

    sport_shift0 #(.DW(BYTE_W), .DIV(M0_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_tx(sh_start_tx), .start_rx(sh_start_rx),
        .din(reg_wdata), .rxd_s(rxd_s), .sclk(sh_sclk), .dout(sh_dout), .oe(sh_oe),
        .busy(sh_busy), .tx_done(sh_tx_done), .rx_done(sh_rx_done), .rx_data(sh_rx_data)
    );

    sport_urx #(.DW(BYTE_W), .SPB(SUB_PER_BIT)) u_urx (
        .clk(clk), .rst_n(rst_n), .enable(mode_async && t_q.ctrl.ren),
        .subtick(subtick), .rxd_s(rxd_s), .done(urx_done), .stop_bit(urx_stop),
        .data(urx_data)
    );

    always_comb begin
        t_d      = t_q;
        t_d.sync = {t_q.sync[0], rxd_in};
        if (wr_ctrl) t_d.ctrl = ctrl_t'(reg_wdata);
        if (utx_done || sh_tx_done) t_d.ctrl.txf = 1'b1;
        if (urx_done && !t_q.ctrl.rxf && (!t_q.ctrl.filt || urx_stop)) begin
            t_d.rbuf       = urx_data;
            t_d.ctrl.rstop = urx_stop;
            t_d.ctrl.rxf   = 1'b1;
        end
        if (sh_rx_done && !t_q.ctrl.rxf) begin
            t_d.rbuf     = sh_rx_data;
            t_d.ctrl.rxf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.sync <= 2'b11;
        end else begin
            t_q <= t_d;
        end
    end

    assign reg_rdata = reg_sel ? t_q.rbuf : t_q.ctrl;
    assign txd       = sh_busy ? sh_sclk : utx_txd;
    assign rxd_out   = sh_dout;
    assign rxd_oe    = sh_oe;
    assign ti        = t_q.ctrl.txf;
    assign ri        = t_q.ctrl.rxf;
    assign irq       = ti || ri;

    // R13: flags are cleared only through a control write
    p_ti_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ti && !wr_ctrl) |=> ti)
        else $error("transmit flag dropped by hardware");

    p_ri_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !wr_ctrl) |=> ri)
        else $error("receive flag dropped by hardware");

    // R10: the receive buffer is frozen while the receive flag is set
    p_buf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ri |=> $stable(t_q.rbuf))
        else $error("buffer overwritten while unread");

    // R6: the two transmit engines never run together
    p_one_engine_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_busy && utx_busy))
        else $error("both engines busy");

endmodule

// File: tb/sport_engine_test.sv
module sport_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       baud_ovf = 1'b0;
    logic       baud_dbl = 1'b1;
    logic       rxd_in = 1'b1;
    logic       rxd_out, rxd_oe, txd, ti, ri, irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sport_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_ovf(baud_ovf),
        .baud_dbl(baud_dbl), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
        .txd(txd), .ti(ti), .ri(ri), .irq(irq)
    );

    // overflow pulse every fourth clock
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            baud_ovf = (ph == 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic m0_tx(input logic [7:0] d);
        int errs;
        logic [7:0] v;
        errs = 0;
        wr(1'b1, d);
        for (int n = 0; n < 96; n++) begin
            if (txd !== ((n % 12) >= 6)) errs++;
            if (rxd_out !== d[n / 12]) errs++;
            if (rxd_oe !== 1'b1) errs++;
            @(negedge clk);
        end
        chk("R6 shift frame pattern", errs, 0);
        chk("R6 done flag at 96", ti, 1);
        chk("R6 driver released", rxd_oe, 0);
        rd(1'b1, v);
        chk("R3 data read unaffected by write", v, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic m0_rx(input logic [7:0] d);
        int lows;
        logic [7:0] v;
        rxd_in = d[0];
        wr(1'b0, 8'h10);
        while (txd !== 1'b0) @(negedge clk);
        for (int k = 1; k < 8; k++) begin
            while (txd !== 1'b1) @(negedge clk);
            while (txd !== 1'b0) @(negedge clk);
            rxd_in = d[k];
        end
        while (txd !== 1'b1) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R7 receive flag", ri, 1);
        lows = 0;
        for (int n = 0; n < 50; n++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
        chk("R7 no restart while flag set", lows, 0);
        wr(1'b0, 8'h00);
        rd(1'b1, v);
        chk("R7 shifted-in byte", v, d);
        rxd_in = 1'b1;
    endtask

    task automatic m1_tx(input logic [7:0] d, input int bitclk, input int tlo,
                         input int thi, input bit inject, input string tag);
        int errs, n, k, exp_b, hi;
        errs = 0;
        n = 0;
        wr(1'b1, d);
        while (!ti && n < bitclk * 12) begin
            if (n % bitclk == bitclk / 2) begin
                k = n / bitclk;
                exp_b = (k == 0) ? 0 : ((k == 9) ? 1 : int'(d[k - 1]));
                if (txd !== exp_b[0]) errs++;
            end
            if (inject && n == 100) begin reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00; end
            if (inject && n == 101) reg_wr = 1'b0;
            @(negedge clk);
            n++;
        end
        chk({tag, " frame bits"}, errs, 0);
        chk({tag, " frame length in range"}, (n >= tlo && n <= thi), 1);
        hi = 0;
        for (int m = 0; m < 300; m++) begin
            if (txd !== 1'b1) hi++;
            @(negedge clk);
        end
        chk({tag, " line idle after frame"}, hi, 0);
        wr(1'b0, 8'h40);
    endtask

    task automatic m1_send(input logic [7:0] d, input logic stop, input int bitclk);
        @(negedge clk);
        rxd_in = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_in = d[i];
            repeat (bitclk) @(negedge clk);
        end
        rxd_in = stop;
        repeat (bitclk) @(negedge clk);
        rxd_in = 1'b1;
        repeat (bitclk) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 control reset", v, 8'h00);
        rd(1'b1, v); chk("R1 data reset", v, 8'h00);
        chk("R1 txd idle", txd, 1);
        chk("R1 oe off", rxd_oe, 0);
        chk("R1 irq off", {ti, ri, irq}, 0);

        // R2 layout and R13 sticky flags
        wr(1'b0, 8'h8B);
        rd(1'b0, v); chk("R2 control readback", v, 8'h8B);
        chk("R2 flag pins", {ti, ri, irq}, 3'b111);
        repeat (100) @(negedge clk);
        chk("R13 flags held", {ti, ri}, 2'b11);
        wr(1'b0, 8'h00);
        chk("R13 flags cleared by write", {ti, ri}, 2'b00);

        // R6 shift-register transmit sweep
        m0_tx(8'hA5);
        m0_tx(8'h01);
        m0_tx(8'h80);
        m0_tx(8'h3C);

        // R9 shift mode with reception off
        lows = 0;
        for (int n = 0; n < 200; n++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
        chk("R9 no shift clock when disabled", lows, 0);
        chk("R9 no receive flag", ri, 0);

        // R7 shift-register receive sweep
        m0_rx(8'h96);
        m0_rx(8'h01);
        m0_rx(8'hE7);

        // R4, R14 asynchronous transmit, doubled rate (64 clocks per bit)
        wr(1'b0, 8'h40);
        baud_dbl = 1'b1;
        m1_tx(8'h5A, 64, 630, 645, 1'b1, "R4 R14");
        m1_tx(8'hFF, 64, 630, 645, 1'b0, "R4");
        // R5 undoubled rate (128 clocks per bit)
        baud_dbl = 1'b0;
        m1_tx(8'hC6, 128, 1265, 1290, 1'b0, "R5 tx");
        baud_dbl = 1'b1;

        // R8 asynchronous receive
        wr(1'b0, 8'h50);
        m1_send(8'h5A, 1'b1, 64);
        rd(1'b1, v); chk("R8 byte", v, 8'h5A);
        rd(1'b0, v); chk("R8 stop bit and flag", v, 8'h55);

        // R10 unread byte keeps buffer
        m1_send(8'hC3, 1'b1, 64);
        rd(1'b1, v); chk("R10 buffer kept", v, 8'h5A);

        // R11 filter on
        wr(1'b0, 8'h70);
        m1_send(8'h11, 1'b0, 64);
        chk("R11 zero stop dropped", ri, 0);
        rd(1'b1, v); chk("R11 buffer after drop", v, 8'h5A);
        m1_send(8'h33, 1'b1, 64);
        rd(1'b1, v); chk("R11 one stop accepted", v, 8'h33);
        // R11 filter off, zero stop accepted
        wr(1'b0, 8'h50);
        m1_send(8'h22, 1'b0, 64);
        rd(1'b1, v); chk("R11 byte with zero stop", v, 8'h22);
        rd(1'b0, v); chk("R11 stop copy zero", v, 8'h51);

        // R9 asynchronous, reception off
        wr(1'b0, 8'h40);
        m1_send(8'h99, 1'b1, 64);
        chk("R9 async disabled flag", ri, 0);
        rd(1'b1, v); chk("R9 async buffer kept", v, 8'h22);

        // R12 false start
        wr(1'b0, 8'h50);
        @(negedge clk);
        rxd_in = 1'b0;
        repeat (16) @(negedge clk);
        rxd_in = 1'b1;
        repeat (700) @(negedge clk);
        chk("R12 glitch ignored", ri, 0);
        m1_send(8'h77, 1'b1, 64);
        rd(1'b1, v); chk("R12 next frame ok", v, 8'h77);

        // R5 receive at undoubled rate
        wr(1'b0, 8'h50);
        baud_dbl = 1'b0;
        m1_send(8'hA3, 1'b1, 128);
        rd(1'b1, v); chk("R5 rx slow rate", v, 8'hA3);
        chk("R5 rx flag", ri, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule